// File: doc/BRIEF.md
# Error Snapshot Trap Controller

This block logs hardware error events into a status word and decides when to raise a disrupting trap. A trap fires when an error bit that was clear becomes set while the matching bit in an enable word is also set. On that edge the block copies the updated status word into a pending register and sets that register's valid flag. While the flag stays set, later errors are still logged but raise no trap and leave the copy unchanged.

Software reaches three 64-bit registers through a simple strobe port: status, enable and pending. It reads the frozen copy from the pending register. Writing 0 to the valid bit re-arms the trap. A warm reset clears the live status and enable words but keeps the pending copy, so the cause of the last trap can still be read after the reset. A cold reset clears everything.

Top module: `err_snap_trap`

## Requirements
- R1: A cold reset (`rst_n` low, release synchronised over two clock edges) clears status, enable, the pending word, `reg_rdata` and `trap_pulse` to zero.
- R2: A 1 in `err_set[i]` sets status bit i. A write to byte offset 0x000 clears every status bit where `reg_wdata` holds a 1. When the same bit is set and cleared in one cycle, the set wins.
- R3: `trap_pulse` rises for exactly one cycle, on the edge after a cycle in which some bit has `err_set`=1, status=0 and enable=1, provided the valid flag is 0. An error whose enable bit is 0, or whose status bit is already 1, raises no trap.
- R4: On the edge that raises a trap, pending bits [ERR_W-1:0] take the status value as updated on that same edge, and pending bit 63 (valid) becomes 1.
- R5: While valid is 1, no trap is raised and the pending word does not change. Errors are still logged in status.
- R6: A write to offset 0x028 loads pending bit 63 and bits [ERR_W-1:0] from `reg_wdata`. Writing 0 to bit 63 re-arms the trap. If a trap fires in the same cycle, the trap update wins.
- R7: A warm reset (`warm_rst_n` low, sampled on the clock) clears status and enable, blocks traps, and leaves the pending word unchanged.
- R8: `reg_rdata` takes the addressed word on the edge after `reg_rd`. Pending bits 62 down to ERR_W read 0. Reads of any other offset return 0, and writes to any other offset change nothing.
- R9: Offset 0x008 is the enable word. A write loads bits [ERR_W-1:0], and the upper bits read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Cold reset, asynchronous, active low |
| warm_rst_n | input | 1 | Warm reset, synchronous, active low |
| err_set | input | ERR_W | Error event per status bit |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte offset of register |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data, valid the cycle after `reg_rd` |
| trap_pulse | output | 1 | One-cycle disrupting trap request |

## Verification
The trap decision is driven with errors that are disabled, newly set with enable, already logged, and arriving while valid is held. These four patterns separate the enable gating, the edge detection and the blocking by the valid flag. Some stimuli happen in the same cycle on purpose. A clear and a set of one status bit shows which has priority. A software pending write with a trap shows that the trap wins, and a warm reset with a held snapshot shows the copy is kept. Reads of unmapped offsets and of the padding bits check that stray writes change nothing visible.

// File: rtl/err_snap_pkg.sv
package err_snap_pkg;
  localparam int DATA_W    = 64;
  localparam int VALID_BIT = 63;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_STATUS,
    SEL_ENABLE,
    SEL_PEND
  } reg_sel_e;
endpackage

// File: rtl/esr_rst_sync.sv
module esr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/esr_log_regs.sv
module esr_log_regs #(
  parameter int ERR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             warm_rst_n,
  input  logic [ERR_W-1:0] err_set,
  input  logic             st_wr,
  input  logic             en_wr,
  input  logic [ERR_W-1:0] wdata,
  output logic [ERR_W-1:0] status_q,
  output logic [ERR_W-1:0] enable_q,
  output logic [ERR_W-1:0] status_nxt,
  output logic [ERR_W-1:0] hit_vec
);
  logic [ERR_W-1:0] status_d;
  logic [ERR_W-1:0] enable_d;
  logic [ERR_W-1:0] clr_mask;
  logic             enable_en;

  always_comb begin
    clr_mask  = st_wr ? wdata : '0;
    enable_en = en_wr | ~warm_rst_n;
    if (!warm_rst_n) begin
      status_d = '0;
      enable_d = '0;
    end else begin
      status_d = (status_q & ~clr_mask) | err_set;
      enable_d = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      enable_q <= '0;
    end else begin
      status_q <= status_d;
      if (enable_en) enable_q <= enable_d;
    end
  end

  assign status_nxt = status_d;
  assign hit_vec    = err_set & ~status_q & enable_q;
endmodule

// File: rtl/esr_trap_ctl.sv
module esr_trap_ctl #(
  parameter int ERR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             warm_rst_n,
  input  logic [ERR_W-1:0] hit_vec,
  input  logic [ERR_W-1:0] status_nxt,
  input  logic             pend_wr,
  input  logic             pend_wr_valid,
  input  logic [ERR_W-1:0] pend_wr_snap,
  output logic             pend_valid_q,
  output logic [ERR_W-1:0] pend_snap_q,
  output logic             trap_q
);
  logic             trap_fire;
  logic             pend_en;
  logic             pend_valid_d;
  logic [ERR_W-1:0] pend_snap_d;

  always_comb begin
    trap_fire = warm_rst_n & (|hit_vec) & ~pend_valid_q;
    pend_en   = trap_fire | pend_wr;
    if (trap_fire) begin
      pend_valid_d = 1'b1;
      pend_snap_d  = status_nxt;
    end else begin
      pend_valid_d = pend_wr_valid;
      pend_snap_d  = pend_wr_snap;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_valid_q <= 1'b0;
      pend_snap_q  <= '0;
      trap_q       <= 1'b0;
    end else begin
      trap_q <= trap_fire;
      if (pend_en) begin
        pend_valid_q <= pend_valid_d;
        pend_snap_q  <= pend_snap_d;
      end
    end
  end
endmodule

// File: rtl/esr_rd_port.sv
module esr_rd_port
  import err_snap_pkg::*;
#(
  parameter int ERR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd,
  input  reg_sel_e          sel,
  input  logic [ERR_W-1:0]  status_q,
  input  logic [ERR_W-1:0]  enable_q,
  input  logic              pend_valid_q,
  input  logic [ERR_W-1:0]  pend_snap_q,
  output logic [DATA_W-1:0] rdata
);
  localparam int PAD_W = DATA_W - 1 - ERR_W;

  logic [DATA_W-1:0] rdata_d;

  always_comb begin
    case (sel)
      SEL_STATUS: rdata_d = {{(DATA_W-ERR_W){1'b0}}, status_q};
      SEL_ENABLE: rdata_d = {{(DATA_W-ERR_W){1'b0}}, enable_q};
      SEL_PEND:   rdata_d = {pend_valid_q, {PAD_W{1'b0}}, pend_snap_q};
      default:    rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata <= '0;
    else if (rd) rdata <= rdata_d;
  end
endmodule

// File: rtl/err_snap_trap.sv
module err_snap_trap
  import err_snap_pkg::*;
#(
  parameter int              ERR_W      = 16,
  parameter int              ADDR_W     = 12,
  parameter int              SYNC_STG   = 2,
  parameter logic [11:0]     STATUS_OFS = 12'h000,
  parameter logic [11:0]     ENABLE_OFS = 12'h008,
  parameter logic [11:0]     PEND_OFS   = 12'h028
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              warm_rst_n,
  input  logic [ERR_W-1:0]  err_set,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [63:0]       reg_wdata,
  output logic [63:0]       reg_rdata,
  output logic              trap_pulse
);
  logic             rst_sync_n;
  reg_sel_e         sel;
  logic             st_wr;
  logic             en_wr;
  logic             pend_wr;
  logic [ERR_W-1:0] status_q;
  logic [ERR_W-1:0] enable_q;
  logic [ERR_W-1:0] status_nxt;
  logic [ERR_W-1:0] hit_vec;
  logic             pend_valid_q;
  logic [ERR_W-1:0] pend_snap_q;

  always_comb begin
    if (reg_addr == ADDR_W'(STATUS_OFS))      sel = SEL_STATUS;
    else if (reg_addr == ADDR_W'(ENABLE_OFS)) sel = SEL_ENABLE;
    else if (reg_addr == ADDR_W'(PEND_OFS))   sel = SEL_PEND;
    else                                      sel = SEL_NONE;
    st_wr   = reg_wr && (sel == SEL_STATUS);
    en_wr   = reg_wr && (sel == SEL_ENABLE);
    pend_wr = reg_wr && (sel == SEL_PEND);
  end

  esr_rst_sync #(.STAGES(SYNC_STG)) u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  esr_log_regs #(.ERR_W(ERR_W)) u_log (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .warm_rst_n (warm_rst_n),
    .err_set    (err_set),
    .st_wr      (st_wr),
    .en_wr      (en_wr),
    .wdata      (reg_wdata[ERR_W-1:0]),
    .status_q   (status_q),
    .enable_q   (enable_q),
    .status_nxt (status_nxt),
    .hit_vec    (hit_vec)
  );

  esr_trap_ctl #(.ERR_W(ERR_W)) u_trap (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .warm_rst_n    (warm_rst_n),
    .hit_vec       (hit_vec),
    .status_nxt    (status_nxt),
    .pend_wr       (pend_wr),
    .pend_wr_valid (reg_wdata[VALID_BIT]),
    .pend_wr_snap  (reg_wdata[ERR_W-1:0]),
    .pend_valid_q  (pend_valid_q),
    .pend_snap_q   (pend_snap_q),
    .trap_q        (trap_pulse)
  );

  esr_rd_port #(.ERR_W(ERR_W)) u_rd (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .rd           (reg_rd),
    .sel          (sel),
    .status_q     (status_q),
    .enable_q     (enable_q),
    .pend_valid_q (pend_valid_q),
    .pend_snap_q  (pend_snap_q),
    .rdata        (reg_rdata)
  );
endmodule

// File: rtl/esr_snap_chk.sv
module esr_snap_chk #(
  parameter int ERR_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             warm_rst_n,
  input logic             trap_pulse,
  input logic             pend_valid,
  input logic [ERR_W-1:0] pend_snap,
  input logic [ERR_W-1:0] status_q,
  input logic [ERR_W-1:0] hit_vec,
  input logic             pend_wr
);
  AST_TRAP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    trap_pulse |-> ($past(|hit_vec) && !$past(pend_valid))); // R3

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    trap_pulse |=> !trap_pulse); // R3

  AST_SNAP_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    trap_pulse |-> (pend_valid && (pend_snap == status_q))); // R4

  AST_NO_TRAP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    pend_valid |=> !trap_pulse); // R5

  AST_SNAP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_valid && !pend_wr) |=> (pend_valid && $stable(pend_snap))); // R5

  AST_WARM_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (!warm_rst_n && !pend_wr) |=> ($stable(pend_valid) && $stable(pend_snap))); // R7
endmodule

bind err_snap_trap esr_snap_chk #(.ERR_W(ERR_W)) u_snap_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .warm_rst_n (warm_rst_n),
  .trap_pulse (trap_pulse),
  .pend_valid (pend_valid_q),
  .pend_snap  (pend_snap_q),
  .status_q   (status_q),
  .hit_vec    (hit_vec),
  .pend_wr    (pend_wr)
);

// File: tb/test_err_snap_trap.sv
`timescale 1ns/1ps
module test_err_snap_trap;
  localparam int ERR_W  = 16;
  localparam int ADDR_W = 12;
  localparam logic [ADDR_W-1:0] A_ST = 12'h000;
  localparam logic [ADDR_W-1:0] A_EN = 12'h008;
  localparam logic [ADDR_W-1:0] A_PD = 12'h028;
  localparam logic [ADDR_W-1:0] A_XX = 12'h010;
  localparam logic [63:0] VBIT = 64'h8000_0000_0000_0000;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              warm_rst_n = 1'b1;
  logic [ERR_W-1:0]  err_set = '0;
  logic              reg_wr = 1'b0;
  logic              reg_rd = 1'b0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic [63:0]       reg_wdata = '0;
  logic [63:0]       reg_rdata;
  logic              trap_pulse;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  typedef struct {
    logic [63:0] exp;
    string       tag;
  } exp_t;
  exp_t exp_q[$];
  logic rd_seen = 1'b0;

  always #4 clk = ~clk;

  err_snap_trap #(.ERR_W(ERR_W), .ADDR_W(ADDR_W)) i_err_snap_trap (
    .clk        (clk),
    .rst_n      (rst_n),
    .warm_rst_n (warm_rst_n),
    .err_set    (err_set),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .trap_pulse (trap_pulse)
  );

  always @(posedge clk) rd_seen <= reg_rd;

  // monitor: pops one expected word per completed read
  always @(negedge clk) begin
    if (rd_seen) begin
      exp_t e;
      n_vec++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL scoreboard: read result with no expected item, actual %h expected none", reg_rdata);
      end else begin
        e = exp_q.pop_front();
        if (reg_rdata !== e.exp) begin
          n_bad++;
          $display("FAIL %s: rdata actual %h expected %h", e.tag, reg_rdata, e.exp);
        end
      end
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [63:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, input logic [63:0] exp, input string tag);
    exp_t e;
    e.exp = exp; e.tag = tag;
    exp_q.push_back(e);
    reg_rd = 1'b1; reg_addr = a;
    tick();
    reg_rd = 1'b0;
  endtask

  task automatic err(input logic [ERR_W-1:0] v);
    err_set = v;
    tick();
    err_set = '0;
  endtask

  task automatic cold_reset();
    rst_n = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (3) tick();
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    tick();
    cold_reset();
    chk(64'(trap_pulse), 64'd0, "R1 trap after reset");
    chk(reg_rdata, 64'd0, "R1 rdata after reset");
    rd(A_ST, 64'd0, "R1 status");
    rd(A_EN, 64'd0, "R1 enable");
    rd(A_PD, 64'd0, "R1 pending");

    wr(A_EN, 64'h0000_0000_0000_00F0);
    rd(A_EN, 64'h00F0, "R9 enable load");

    err(16'h0001);
    chk(64'(trap_pulse), 64'd0, "R3 disabled error");
    err(16'h0010);
    chk(64'(trap_pulse), 64'd1, "R3 enabled new error");
    tick();
    chk(64'(trap_pulse), 64'd0, "R3 single pulse");
    rd(A_PD, VBIT | 64'h0011, "R4 snapshot");

    err(16'h0020);
    chk(64'(trap_pulse), 64'd0, "R5 no trap while valid");
    rd(A_ST, 64'h0031, "R5 still logged");
    rd(A_PD, VBIT | 64'h0011, "R5 snapshot held");

    wr(A_PD, 64'd0);
    rd(A_PD, 64'd0, "R6 valid cleared");
    err(16'h0010);
    chk(64'(trap_pulse), 64'd0, "R3 already logged bit");

    wr(A_ST, 64'h0010);
    rd(A_ST, 64'h0021, "R2 write one clears");
    err(16'h0010);
    chk(64'(trap_pulse), 64'd1, "R6 rearmed trap");
    rd(A_PD, VBIT | 64'h0031, "R4 second snapshot");

    reg_wr = 1'b1; reg_addr = A_ST; reg_wdata = 64'h0002; err_set = 16'h0002;
    tick();
    reg_wr = 1'b0; reg_wdata = '0; err_set = '0;
    rd(A_ST, 64'h0033, "R2 set wins over clear");

    warm_rst_n = 1'b0;
    tick();
    warm_rst_n = 1'b1;
    rd(A_ST, 64'd0, "R7 status cleared");
    rd(A_EN, 64'd0, "R7 enable cleared");
    rd(A_PD, VBIT | 64'h0031, "R7 pending kept");

    wr(A_XX, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(A_XX, 64'd0, "R8 unmapped read");
    rd(A_ST, 64'd0, "R8 unmapped write status");
    rd(A_EN, 64'd0, "R8 unmapped write enable");

    wr(A_EN, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(A_EN, 64'h0000_0000_0000_FFFF, "R9 upper bits zero");

    wr(A_PD, 64'd0);
    reg_wr = 1'b1; reg_addr = A_PD; reg_wdata = 64'h1234; err_set = 16'h0100;
    tick();
    reg_wr = 1'b0; reg_wdata = '0; err_set = '0;
    chk(64'(trap_pulse), 64'd1, "R6 trap with write");
    rd(A_PD, VBIT | 64'h0100, "R6 trap wins over write");

    wr(A_PD, VBIT | 64'h00AA);
    rd(A_PD, VBIT | 64'h00AA, "R6 software load");
    err(16'h0200);
    chk(64'(trap_pulse), 64'd0, "R5 software valid blocks");

    wr(A_PD, 64'h7FFF_0000_0000_0000);
    rd(A_PD, 64'd0, "R8 pending padding zero");

    cold_reset();
    chk(64'(trap_pulse), 64'd0, "R1 trap after second reset");
    rd(A_PD, 64'd0, "R1 pending cleared");
    rd(A_ST, 64'd0, "R1 status cleared");
    rd(A_EN, 64'd0, "R1 enable cleared");

    repeat (3) tick();
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL scoreboard: %0d reads unanswered, expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule